// File: doc/BRIEF.md
# SPI Register-Access Command Decoder

This block is an SPI mode 0 target that turns short framed transactions from a host into single-cycle read and write strobes for a small register file. The SPI pins (SCK, chip select, serial data in) are brought into the system clock domain through two-flop synchronizers. Edges of SCK are detected in that clock domain, so the system clock must run several times faster than SCK.

A frame has three bytes, each sent most significant bit first. The first is a fixed tag byte that must equal 0x50. The second holds an operation code and a register pointer. The third is either write data coming from the host, or read data that the block returns on its serial output. A frame with a wrong tag or an unknown operation is dropped, and the block takes no further action until chip select goes high again. Raising chip select at any point abandons the frame in progress.

Top module: `spi_cmd_decoder`

## Requirements
- R1: After reset, `reg_rd`, `reg_wr` and `sdo_oe` are 0, and `reg_addr` and `reg_wdata` are 0.
- R2: A frame is decoded only when its first byte is 0x50. With any other first byte, no strobe is issued and `sdo_oe` stays 0 for the rest of that frame.
- R3: In the second byte, bits 7:4 are the operation code, bits 3:2 must be 00, and bits 1:0 are the register pointer. Operation code 1011 means read and 1100 means write. Any other code, or nonzero bits 3:2, drops the frame with no strobe.
- R4: For a write, once all 8 bits of the third byte have arrived with chip select low, `reg_wr` is high for exactly one clock. During that clock `reg_addr` holds the pointer and `reg_wdata` holds the third byte.
- R5: For a read, `reg_rd` is high for exactly one clock after the second byte completes, with `reg_addr` holding the pointer. `reg_rdata` is captured in that same clock.
- R6: During the third byte of a read, `sdo` presents the captured data MSB first. Each bit changes only after an SCK falling edge and is stable at the following SCK rising edge.
- R7: `sdo_oe` is 1 only while chip select is low and the data byte of a read is in progress. It is 0 during the tag and command bytes, throughout write frames, and whenever chip select is high.
- R8: A rise of chip select partway through a frame aborts it with no strobe. The next frame is decoded from its first byte.
- R9: Bytes that follow the data byte in the same frame are ignored, so each frame issues at most one strobe.
- R10: `reg_rd` and `reg_wr` are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock from the host |
| cs_n | input | 1 | Active-low chip select from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | Output enable for `sdo` (1 drives the pin) |
| reg_rd | output | 1 | One-clock read strobe |
| reg_wr | output | 1 | One-clock write strobe |
| reg_addr | output | 2 | Register pointer for the strobe |
| reg_wdata | output | 8 | Write data, valid during `reg_wr` |
| reg_rdata | input | 8 | Read data, sampled during `reg_rd` |

## Verification
The assertions rely on a few conditions at the block's inputs. Chip select must stay low for at least three system clocks after the last SCK rising edge of a frame. Each SCK level must last several system clocks. `reg_rdata` must be valid in the same clock as `reg_rd`. The bench meets these conditions by using SCK half-periods of eight system clocks and by holding chip select low for a full half-period on either side of the bit stream. Its register file model returns `reg_rdata` combinationally from `reg_addr`.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned OP_W   = 4;
  localparam logic [BYTE_W-1:0] TAG_BYTE = 8'h50;
  localparam logic [OP_W-1:0]   OP_READ  = 4'b1011;
  localparam logic [OP_W-1:0]   OP_WRITE = 4'b1100;

  typedef enum logic [1:0] {
    FR_TAG  = 2'd0,
    FR_CMD  = 2'd1,
    FR_DATA = 2'd2,
    FR_DROP = 2'd3
  } frame_st_t;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned       WIDTH   = 3,
  parameter int unsigned       STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    logic              prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q <= {STAGES{RST_VAL[g]}};
        prev_q <= RST_VAL[g];
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], din[g]};
        prev_q <= pipe_q[STAGES-1];
      end
    end
    assign dout[g] = pipe_q[STAGES-1];
    assign rise[g] = pipe_q[STAGES-1] & ~prev_q;
    assign fall[g] = ~pipe_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sck_rise,
  input  logic              sdi,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              cnt_zero
);
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;

  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    if (!sel) begin
      cnt_d = '0;
    end else if (sck_rise) begin
      cnt_d = cnt_q + 1'b1;
      sh_d  = {sh_q[BYTE_W-2:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
    end
  end

  assign byte_val  = {sh_q[BYTE_W-2:0], sdi};
  assign byte_done = sel & sck_rise & (cnt_q == CNT_W'(BYTE_W-1));
  assign cnt_zero  = (cnt_q == '0);
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  output frame_st_t         state,
  output logic              is_read,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] addr,
  output logic [BYTE_W-1:0] wdata
);
  localparam int unsigned PAD_W = BYTE_W - OP_W - ADDR_W;

  frame_st_t         st_q, st_d;
  logic              isrd_q, isrd_d, rd_d, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BYTE_W-1:0] wd_q, wd_d;
  logic [OP_W-1:0]   op;
  logic              pad_ok;

  assign op     = byte_val[BYTE_W-1 -: OP_W];
  assign pad_ok = (byte_val[ADDR_W +: PAD_W] == '0);

  always_comb begin
    st_d   = st_q;
    isrd_d = isrd_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    rd_d   = 1'b0;
    wr_d   = 1'b0;
    if (!sel) begin
      st_d = FR_TAG;
    end else if (byte_done) begin
      case (st_q)
        FR_TAG:  st_d = (byte_val == TAG_BYTE) ? FR_CMD : FR_DROP;
        FR_CMD: begin
          if (pad_ok && (op == OP_READ)) begin
            st_d   = FR_DATA;
            isrd_d = 1'b1;
            rd_d   = 1'b1;
            addr_d = byte_val[ADDR_W-1:0];
          end else if (pad_ok && (op == OP_WRITE)) begin
            st_d   = FR_DATA;
            isrd_d = 1'b0;
            addr_d = byte_val[ADDR_W-1:0];
          end else begin
            st_d = FR_DROP;
          end
        end
        FR_DATA: begin
          st_d = FR_DROP;
          if (!isrd_q) begin
            wr_d = 1'b1;
            wd_d = byte_val;
          end
        end
        default: st_d = FR_DROP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FR_TAG;
      isrd_q <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
      rd_stb <= 1'b0;
      wr_stb <= 1'b0;
    end else begin
      st_q   <= st_d;
      isrd_q <= isrd_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      rd_stb <= rd_d;
      wr_stb <= wr_d;
    end
  end

  assign state   = st_q;
  assign is_read = isrd_q;
  assign addr    = addr_q;
  assign wdata   = wd_q;
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_val,
  input  logic              shift_en,
  output logic              bit_out
);
  logic [BYTE_W-1:0] tx_q, tx_d;

  always_comb begin
    tx_d = tx_q;
    if (load)          tx_d = load_val;
    else if (shift_en) tx_d = {tx_q[BYTE_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tx_q <= '0;
    else        tx_q <= tx_d;
  end

  assign bit_out = tx_q[BYTE_W-1];
endmodule

// File: rtl/spi_cmd_decoder.sv
module spi_cmd_decoder
  import spi_cmd_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] reg_wdata,
  input  logic [BYTE_W-1:0] reg_rdata
);
  localparam int unsigned PIN_N = 3;
  localparam logic [PIN_N-1:0] PIN_RST = 3'b010;

  logic [PIN_N-1:0]  pin_s, pin_r, pin_f;
  logic              sel, byte_done, cnt_zero, is_read;
  logic [BYTE_W-1:0] byte_val;
  frame_st_t         state;
  logic              in_rd_data;

  spi_in_sync #(.WIDTH(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sdi, cs_n, sck}),
    .dout(pin_s), .rise(pin_r), .fall(pin_f)
  );

  assign sel = ~pin_s[1];

  spi_rx_shift #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sel(sel), .sck_rise(pin_r[0]), .sdi(pin_s[2]),
    .byte_done(byte_done), .byte_val(byte_val), .cnt_zero(cnt_zero)
  );

  spi_frame_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .sel(sel), .byte_done(byte_done),
    .byte_val(byte_val), .state(state), .is_read(is_read),
    .rd_stb(reg_rd), .wr_stb(reg_wr), .addr(reg_addr), .wdata(reg_wdata)
  );

  assign in_rd_data = (state == FR_DATA) & is_read;

  spi_tx_shift #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(reg_rd), .load_val(reg_rdata),
    .shift_en(pin_f[0] & in_rd_data & ~cnt_zero), .bit_out(sdo)
  );

  assign sdo_oe = sel & in_rd_data;
endmodule

module spi_cmd_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic sdo_oe,
  input logic reg_rd,
  input logic reg_wr
);
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr)); // R10
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr); // R4
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd); // R5
  AST_WR_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !$past(cs_n, 3)); // R4
  AST_WR_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !sdo_oe); // R7
  AST_RD_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> sdo_oe); // R7
  AST_OE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !sdo_oe); // R7
endmodule

bind spi_cmd_decoder spi_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo_oe(sdo_oe),
  .reg_rd(reg_rd), .reg_wr(reg_wr)
);

// File: tb/spi_cmd_decoder_tb.sv
module spi_cmd_decoder_tb;
  localparam time TCLK = 8ns;
  localparam time HALF = 64ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, reg_rd, reg_wr;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic [7:0] mem [4];

  int tests = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, both_cnt = 0;
  logic [1:0] last_wa;
  logic [7:0] last_wd;
  bit done = 0;

  always #(TCLK/2) clk = ~clk;

  spi_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always @(negedge clk) begin
    if (reg_wr) begin
      wr_cnt++; last_wa = reg_addr; last_wd = reg_wdata;
      mem[reg_addr] = reg_wdata;
    end
    if (reg_rd) rd_cnt++;
    if (reg_rd && reg_wr) both_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Sends nbits of data (MSB first); captures sdo on rises of byte index 2.
  task automatic frame(input int nbits, input logic [31:0] data,
                       output logic [7:0] rx, output bit oe_b3, output bit oe_other);
    rx = '0; oe_b3 = 0; oe_other = 0;
    cs_n = 1'b0;
    #(HALF);
    for (int i = 0; i < nbits; i++) begin
      sdi = data[31-i];
      #(HALF);
      if (i / 8 == 2) begin
        rx = {rx[6:0], sdo};
        if (sdo_oe) oe_b3 = 1;
      end else if (sdo_oe) oe_other = 1;
      sck = 1'b1;
      #(HALF);
      sck = 1'b0;
    end
    #(HALF);
    cs_n = 1'b1;
    repeat (20) @(posedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 rd", reg_rd, 0);
    chk("R1 wr", reg_wr, 0);
    chk("R1 oe", sdo_oe, 0);
    chk("R1 addr", reg_addr, 0);
    chk("R1 wdata", reg_wdata, 0);
  endtask

  task automatic t_write(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] rx; bit ob, oo; int w0;
    w0 = wr_cnt;
    frame(24, {8'h50, 6'b110000, a, d, 8'h00}, rx, ob, oo);
    chk("R4 count", wr_cnt - w0, 1);
    chk("R4 addr", last_wa, a);
    chk("R4 data", last_wd, d);
    chk("R7 oe in write", ob | oo, 0);
  endtask

  task automatic t_read(input logic [1:0] a, input logic [7:0] d);
    logic [7:0] rx; bit ob, oo; int r0;
    mem[a] = d;
    r0 = rd_cnt;
    frame(24, {8'h50, 6'b101100, a, 8'h00, 8'h00}, rx, ob, oo);
    chk("R5 count", rd_cnt - r0, 1);
    chk("R6 data", rx, d);
    chk("R7 oe in data byte", ob, 1);
    chk("R7 oe in header", oo, 0);
    @(negedge clk);
    chk("R7 oe cs high", sdo_oe, 0);
  endtask

  task automatic t_bad_tag();
    logic [7:0] rx; bit ob, oo; int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    frame(24, {8'h51, 8'hC0, 8'h77, 8'h00}, rx, ob, oo);
    chk("R2 wr", wr_cnt - w0, 0);
    frame(24, {8'h70, 8'hB1, 8'h00, 8'h00}, rx, ob, oo);
    chk("R2 rd", rd_cnt - r0, 0);
    chk("R2 oe", ob | oo, 0);
  endtask

  task automatic t_bad_op();
    logic [7:0] rx; bit ob, oo; int w0, r0;
    w0 = wr_cnt; r0 = rd_cnt;
    frame(24, {8'h50, 8'hA1, 8'h33, 8'h00}, rx, ob, oo);
    frame(24, {8'h50, 8'hC4, 8'h33, 8'h00}, rx, ob, oo);
    frame(24, {8'h50, 8'hB8, 8'h00, 8'h00}, rx, ob, oo);
    chk("R3 wr", wr_cnt - w0, 0);
    chk("R3 rd", rd_cnt - r0, 0);
    chk("R3 oe", ob | oo, 0);
  endtask

  task automatic t_abort();
    logic [7:0] rx; bit ob, oo; int w0;
    w0 = wr_cnt;
    frame(20, {8'h50, 8'hC1, 8'hEE, 8'h00}, rx, ob, oo);
    chk("R8 no strobe", wr_cnt - w0, 0);
    frame(12, {8'h50, 8'hC1, 8'h00, 8'h00}, rx, ob, oo);
    chk("R8 no strobe short", wr_cnt - w0, 0);
    t_write(2'd2, 8'h96);
    chk("R8 fresh frame", wr_cnt - w0, 1);
  endtask

  task automatic t_extra();
    logic [7:0] rx; bit ob, oo; int w0;
    w0 = wr_cnt;
    frame(32, {8'h50, 8'hC3, 8'hAA, 8'h55}, rx, ob, oo);
    chk("R9 one strobe", wr_cnt - w0, 1);
    chk("R9 data", last_wd, 8'hAA);
  endtask

  initial begin
    #(200000 * TCLK);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) mem[i] = 8'h00;
    repeat (5) @(posedge clk);
    t_reset();
    #3ns rst_n = 1'b1;
    repeat (5) @(posedge clk);
    t_reset();
    t_write(2'd1, 8'h5A);
    t_write(2'd3, 8'hFF);
    t_read(2'd0, 8'hA5);
    t_read(2'd3, 8'h3C);
    t_read(2'd1, 8'h81);
    t_bad_tag();
    t_bad_op();
    t_abort();
    t_extra();
    chk("R10 exclusive", both_cnt, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule